// File: doc/BRIEF.md
# Translation Cache with Blocking Refill

This block keeps a small, fully associative set of recently used virtual-to-physical page translations and sits between a requester and a page table walker. A requester presents a virtual address with a valid/ready handshake. If a stored translation covers that address, the physical address comes back on the next cycle. If no stored translation covers it, the block asks the walker for the mapping, stores what comes back, and then answers the requester.

Each stored translation describes a page of 4 KB, 2 MB or 1 GB. One large-page translation therefore covers a whole region, and the comparison ignores the virtual bits that fall inside the page. A fault reported by the walker goes back to the requester and leaves the stored set unchanged. A flush input empties the whole set, for example when the active address space changes. A flush that lands while a walk is outstanding also throws away that walk's result.

Top module: `xlat_cache`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `rsp_valid` and `walk_req_valid` are 0. No translation is stored, so the first lookup of any address starts a walk.
- R2: A lookup accepted when `req_valid` and `req_ready` are both 1 at a clock edge, and covered by a stored translation, produces `rsp_valid`=1, `rsp_hit`=1 and `rsp_fault`=0 in the next cycle, together with the translated `rsp_paddr`. No walk is started.
- R3: Page size codes are 0 for 4 KB, 1 for 2 MB and 2 for 1 GB. An entry covers an address when bits VA_W-1 down to 12, 21 or 30 respectively equal the stored ones. The physical address takes the frame bits above the page size and the virtual bits below it, so frame bits inside a large page have no effect.
- R4: A lookup that no entry covers raises `walk_req_valid` in the next cycle, with `walk_req_vpn` equal to the address bits VA_W-1:12. Both stay unchanged until the cycle in which `walk_rsp_valid` is sampled high.
- R5: A walker reply without a fault stores the translation and gives `rsp_valid`=1, `rsp_hit`=0 and the physical address in the next cycle. Later lookups inside the same page hit.
- R6: A walker reply with `walk_rsp_fault`=1 gives `rsp_valid`=1, `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0, and stores nothing, so the same page walks again.
- R7: At most one walk is outstanding. `req_ready` is 0 while `walk_req_valid` is 1.
- R8: A new translation goes into the lowest-numbered empty entry. When every entry is full, it goes into the entry named by a rotating pointer. The pointer is 0 after reset or flush and advances by one, wrapping, after each install that uses it.
- R9: A cycle with `flush`=1 empties every entry and returns the pointer to 0. `req_ready` is 0 during that cycle.
- R10: If `flush` is 1 in any cycle of an outstanding walk, including the cycle of the walker's reply, that reply produces no response and stores nothing. The block then becomes ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries and drop any walk in flight |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_vaddr | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Response came from a stored entry |
| rsp_fault | output | 1 | Walker reported a fault |
| rsp_paddr | output | PA_W | Translated physical address (0 on fault) |
| walk_req_valid | output | 1 | Walk outstanding |
| walk_req_vpn | output | VA_W-12 | Virtual page number to walk |
| walk_rsp_valid | input | 1 | Walker reply present |
| walk_rsp_pfn | input | PA_W-12 | Frame number in 4 KB units |
| walk_rsp_size | input | 2 | Page size code of the reply |
| walk_rsp_fault | input | 1 | Walker found no mapping |

## Verification
The hardest situation to produce from the ports is a flush that lands exactly in the cycle where the walker answers. Only there do the discard of an in-flight result and the install race on the same edge. The bench's walker model takes a programmable reply delay. A delay of zero lets the stimulus put the reply and the flush on the same cycle, and a longer delay puts the flush in the middle of the walk. A second hard case is a full buffer with the rotating pointer past entry 0. A directed sequence fills all sixteen entries and then shows, by which lookups hit and which walk again, which entries were evicted.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int unsigned PG_SHIFT = 12;
    localparam int unsigned LVL_BITS = 9;

    typedef enum logic [1:0] {
        PG_4K   = 2'd0,
        PG_2M   = 2'd1,
        PG_1G   = 2'd2,
        PG_RSVD = 2'd3
    } pg_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } xl_state_e;

    // Number of page-number bits that lie inside the page for a given size.
    function automatic int unsigned vpn_lo_bits(pg_size_e sz);
        case (sz)
            PG_2M:   return LVL_BITS;
            PG_1G:   return 2 * LVL_BITS;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int N     = 16,
    parameter int VPN_W = 36,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     ent_vld,
    input  logic [VPN_W-1:0] ent_vpn [N],
    input  pg_size_e         ent_sz  [N],
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);

    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic [VPN_W-1:0] keep;
        assign keep  = {VPN_W{1'b1}} << vpn_lo_bits(ent_sz[g]);
        assign eq[g] = ent_vld[g] && (((ent_vpn[g] ^ look_vpn) & keep) == '0);
    end

    always_comb begin
        hit     = |eq;
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     ent_vld,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] vic_idx,
    output logic             vic_from_rr
);

    always_comb begin
        vic_idx     = rr_ptr;
        vic_from_rr = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            if (!ent_vld[i]) begin
                vic_idx     = IDX_W'(i);
                vic_from_rr = 1'b0;
            end
        end
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int VA_W    = 48,
    parameter int PA_W    = 44,
    parameter int ENTRIES = 16,
    localparam int VPN_W  = VA_W - int'(PG_SHIFT),
    localparam int PFN_W  = PA_W - int'(PG_SHIFT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             walk_req_valid,
    output logic [VPN_W-1:0] walk_req_vpn,
    input  logic             walk_rsp_valid,
    input  logic [PFN_W-1:0] walk_rsp_pfn,
    input  logic [1:0]       walk_rsp_size,
    input  logic             walk_rsp_fault
);

    localparam int IDX_W = $clog2(ENTRIES);

    // Frame bits above the page size joined with virtual bits below it.
    function automatic logic [PA_W-1:0] make_pa(
        input logic [PFN_W-1:0] pfn,
        input pg_size_e         sz,
        input logic [VA_W-1:0]  va
    );
        logic [PA_W-1:0] hi_m;
        hi_m = {PA_W{1'b1}} << (PG_SHIFT + vpn_lo_bits(sz));
        return ({pfn, {PG_SHIFT{1'b0}}} & hi_m) | (PA_W'(va) & ~hi_m);
    endfunction

    // Entry storage
    logic [ENTRIES-1:0] ent_vld;
    logic [VPN_W-1:0]   ent_vpn [ENTRIES];
    logic [PFN_W-1:0]   ent_pfn [ENTRIES];
    pg_size_e           ent_sz  [ENTRIES];
    logic [IDX_W-1:0]   rr_ptr;

    // Control state
    xl_state_e          state;
    logic [VA_W-1:0]    pend_va;
    logic               drop_q;

    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   vic_idx;
    logic               vic_from_rr;
    logic               accept;
    logic               walk_done;
    logic               install;
    pg_size_e           rsp_sz;

    assign rsp_sz    = pg_size_e'(walk_rsp_size);
    assign req_ready = (state == ST_IDLE) && !flush;
    assign accept    = req_valid && req_ready;
    assign walk_done = (state == ST_WALK) && walk_rsp_valid;
    assign install   = walk_done && !walk_rsp_fault && !drop_q && !flush;

    assign walk_req_valid = (state == ST_WALK);
    assign walk_req_vpn   = pend_va[VA_W-1:PG_SHIFT];

    xlat_match #(.N(ENTRIES), .VPN_W(VPN_W)) match_i (
        .ent_vld  (ent_vld),
        .ent_vpn  (ent_vpn),
        .ent_sz   (ent_sz),
        .look_vpn (req_vaddr[VA_W-1:PG_SHIFT]),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    xlat_victim #(.N(ENTRIES)) victim_i (
        .ent_vld     (ent_vld),
        .rr_ptr      (rr_ptr),
        .vic_idx     (vic_idx),
        .vic_from_rr (vic_from_rr)
    );

    // Request sequencing and response register
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pend_va   <= '0;
            drop_q    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (hit) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b1;
                            rsp_fault <= 1'b0;
                            rsp_paddr <= make_pa(ent_pfn[hit_idx], ent_sz[hit_idx], req_vaddr);
                        end else begin
                            state   <= ST_WALK;
                            pend_va <= req_vaddr;
                            drop_q  <= 1'b0;
                        end
                    end
                end
                ST_WALK: begin
                    if (flush) drop_q <= 1'b1;
                    if (walk_rsp_valid) begin
                        state  <= ST_IDLE;
                        drop_q <= 1'b0;
                        if (!drop_q && !flush) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b0;
                            rsp_fault <= walk_rsp_fault;
                            rsp_paddr <= walk_rsp_fault ? '0
                                       : make_pa(walk_rsp_pfn, rsp_sz, pend_va);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Valid bits and replacement pointer
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ent_vld <= '0;
            rr_ptr  <= '0;
        end else if (install) begin
            ent_vld[vic_idx] <= 1'b1;
            if (vic_from_rr) begin
                rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
            end
        end
    end

    // Entry payload
    always_ff @(posedge clk) begin
        if (install) begin
            ent_vpn[vic_idx] <= pend_va[VA_W-1:PG_SHIFT];
            ent_pfn[vic_idx] <= walk_rsp_pfn;
            ent_sz[vic_idx]  <= rsp_sz;
        end
    end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int VPN_W = 36,
    parameter int PA_W  = 44
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_fault,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             walk_req_valid,
    input logic [VPN_W-1:0] walk_req_vpn,
    input logic             walk_rsp_valid
);

    p_hit_src_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_hit |-> $past(req_valid && req_ready));

    p_accept_outcome_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> (rsp_valid ^ walk_req_valid));

    p_walk_hold_r4: assert property (@(posedge clk) disable iff (rst)
        walk_req_valid && !walk_rsp_valid && !flush |=> walk_req_valid && $stable(walk_req_vpn));

    p_refill_src_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_hit |-> $past(walk_req_valid && walk_rsp_valid));

    p_fault_shape_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault |-> !rsp_hit && (rsp_paddr == '0));

    p_one_walk_r7: assert property (@(posedge clk) disable iff (rst)
        walk_req_valid |-> !req_ready);

    p_flush_block_r9: assert property (@(posedge clk) disable iff (rst)
        flush |-> !req_ready);

    p_flush_drop_r10: assert property (@(posedge clk) disable iff (rst)
        walk_req_valid && walk_rsp_valid && flush |=> !rsp_valid);

endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .PA_W(PA_W)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .flush          (flush),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_fault      (rsp_fault),
    .rsp_paddr      (rsp_paddr),
    .walk_req_valid (walk_req_valid),
    .walk_req_vpn   (walk_req_vpn),
    .walk_rsp_valid (walk_rsp_valid)
);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb_top;

    localparam int VA_W  = 48;
    localparam int PA_W  = 44;
    localparam int NENT  = 16;
    localparam int VPN_W = VA_W - 12;
    localparam int PFN_W = PA_W - 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             flush = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [VA_W-1:0]  req_vaddr = '0;
    logic             rsp_valid, rsp_hit, rsp_fault;
    logic [PA_W-1:0]  rsp_paddr;
    logic             walk_req_valid;
    logic [VPN_W-1:0] walk_req_vpn;
    logic             walk_rsp_valid = 1'b0;
    logic [PFN_W-1:0] walk_rsp_pfn = '0;
    logic [1:0]       walk_rsp_size = '0;
    logic             walk_rsp_fault = 1'b0;

    int tests = 0;
    int fails = 0;
    int wdelay = 1;
    bit done = 1'b0;

    // Bench model of stored translations
    bit               m_vld [NENT];
    logic [VPN_W-1:0] m_vpn [NENT];
    logic [1:0]       m_sz  [NENT];
    logic [PFN_W-1:0] m_pfn [NENT];
    int               m_rr = 0;

    always #5 clk = ~clk;

    xlat_cache #(.VA_W(VA_W), .PA_W(PA_W), .ENTRIES(NENT)) dut_i (
        .clk(clk), .rst(rst), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr),
        .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_pfn(walk_rsp_pfn),
        .walk_rsp_size(walk_rsp_size), .walk_rsp_fault(walk_rsp_fault)
    );

    // Page table: class from 1 GB region index: 0=4K, 1=2M, 2=1G, 3=fault
    function automatic logic [1:0] pt_class(input logic [VPN_W-1:0] vpn);
        return vpn[19:18];
    endfunction

    function automatic int lo_of(input logic [1:0] c);
        return (c == 2'd1) ? 9 : (c == 2'd2) ? 18 : 0;
    endfunction

    function automatic logic [PFN_W-1:0] pt_pfn(input logic [VPN_W-1:0] vpn);
        logic [63:0] base;
        logic [63:0] t;
        base = 64'(vpn & ({VPN_W{1'b1}} << lo_of(pt_class(vpn))));
        t    = (base + 64'd17) * 64'h9E37_79B9_7F4A_7C15;
        return t[45:14];
    endfunction

    function automatic logic [PA_W-1:0] exp_pa(input logic [PFN_W-1:0] pfn,
                                              input logic [1:0] c,
                                              input logic [VA_W-1:0] va);
        logic [PA_W-1:0] lo_m;
        lo_m = (44'd1 << (12 + lo_of(c))) - 44'd1;
        return ({pfn, 12'h000} & ~lo_m) | (va[PA_W-1:0] & lo_m);
    endfunction

    function automatic int m_find(input logic [VPN_W-1:0] vpn);
        for (int i = 0; i < NENT; i++) begin
            logic [VPN_W-1:0] k;
            k = {VPN_W{1'b1}} << lo_of(m_sz[i]);
            if (m_vld[i] && (((m_vpn[i] ^ vpn) & k) == '0)) return i;
        end
        return -1;
    endfunction

    task automatic m_install(input logic [VPN_W-1:0] vpn, input logic [1:0] c,
                             input logic [PFN_W-1:0] pfn);
        int v;
        v = -1;
        for (int i = NENT - 1; i >= 0; i--) if (!m_vld[i]) v = i;
        if (v < 0) begin
            v = m_rr;
            m_rr = (m_rr + 1) % NENT;
        end
        m_vld[v] = 1'b1; m_vpn[v] = vpn; m_sz[v] = c; m_pfn[v] = pfn;
    endtask

    task automatic m_clear();
        for (int i = 0; i < NENT; i++) m_vld[i] = 1'b0;
        m_rr = 0;
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [VA_W-1:0] mk_va(input int reg_i, input int mid,
                                             input int lo, input int off);
        return {18'(reg_i), 9'(mid), 9'(lo), 12'(off)};
    endfunction

    // Walker model
    initial begin
        forever begin
            @(negedge clk);
            if (walk_req_valid) begin
                repeat (wdelay) @(negedge clk);
                walk_rsp_valid = 1'b1;
                walk_rsp_fault = (pt_class(walk_req_vpn) == 2'd3);
                walk_rsp_size  = walk_rsp_fault ? 2'd0 : pt_class(walk_req_vpn);
                walk_rsp_pfn   = pt_pfn(walk_req_vpn);
                @(negedge clk);
                walk_rsp_valid = 1'b0;
            end
        end
    end

    task automatic do_lookup(input logic [VA_W-1:0] va, input string tag);
        int idx;
        int n;
        logic [VPN_W-1:0] vpn;
        logic [1:0] c;
        vpn = va[VA_W-1:12];
        c   = pt_class(vpn);
        idx = m_find(vpn);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        if (idx >= 0) begin
            chk(rsp_valid && rsp_hit && !rsp_fault && !walk_req_valid, tag,
                "hit flags", 64'({rsp_valid, rsp_hit, rsp_fault, walk_req_valid}), 64'b1100);
            chk(rsp_paddr == exp_pa(m_pfn[idx], m_sz[idx], va), tag, "hit paddr",
                64'(rsp_paddr), 64'(exp_pa(m_pfn[idx], m_sz[idx], va)));
        end else begin
            chk(walk_req_valid && !rsp_valid && walk_req_vpn == vpn, tag, "walk vpn",
                64'(walk_req_vpn), 64'(vpn));
            chk(!req_ready, "R7", "ready during walk", 64'(req_ready), 64'd0);
            n = 0;
            while (!rsp_valid && n < 40) begin
                @(negedge clk);
                n++;
            end
            chk(rsp_valid && !rsp_hit && rsp_fault == (c == 2'd3), tag, "refill flags",
                64'({rsp_valid, rsp_hit, rsp_fault}), 64'({1'b1, 1'b0, c == 2'd3}));
            if (c == 2'd3) begin
                chk(rsp_paddr == '0, "R6", "fault paddr", 64'(rsp_paddr), 64'd0);
            end else begin
                chk(rsp_paddr == exp_pa(pt_pfn(vpn), c, va), tag, "refill paddr",
                    64'(rsp_paddr), 64'(exp_pa(pt_pfn(vpn), c, va)));
                m_install(vpn, c, pt_pfn(vpn));
            end
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        #1;
        chk(!req_ready, "R9", "ready in flush cycle", 64'(req_ready), 64'd0);
        @(negedge clk);
        flush = 1'b0;
        m_clear();
    endtask

    // Flush while a walk is outstanding; rsp_same puts it on the reply cycle
    task automatic flush_in_walk(input logic [VA_W-1:0] va, input int dly);
        int n;
        bit seen;
        wdelay = dly;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk(walk_req_valid, "R10", "walk started", 64'(walk_req_valid), 64'd1);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        m_clear();
        seen = rsp_valid;
        n = 0;
        while (walk_req_valid && n < 40) begin
            @(negedge clk);
            seen = seen | rsp_valid;
            n++;
        end
        @(negedge clk);
        seen = seen | rsp_valid;
        chk(!seen, "R10", "dropped reply gave no response", 64'(seen), 64'd0);
        chk(req_ready, "R10", "ready after drop", 64'(req_ready), 64'd1);
        wdelay = 1;
        do_lookup(va, "R10");
    endtask

    initial begin
        process::self().srandom(32'd4242);
        m_clear();
        repeat (3) @(posedge clk);
        #1;
        chk(req_ready && !rsp_valid && !walk_req_valid, "R1", "outputs in reset",
            64'({req_ready, rsp_valid, walk_req_valid}), 64'b100);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready, "R1", "ready after reset", 64'(req_ready), 64'd1);
        chk(!rsp_valid && !walk_req_valid, "R1", "idle after reset",
            64'({rsp_valid, walk_req_valid}), 64'd0);

        // R1/R4/R5: first lookup must walk
        do_lookup(mk_va(0, 0, 5, 'h123), "R4");
        do_lookup(mk_va(0, 0, 5, 'h7ff), "R2");

        // R3: 2 MB page
        do_lookup(mk_va(1, 3, 5, 'h123), "R3");
        do_lookup(mk_va(1, 3, 200, 'h456), "R3");
        do_lookup(mk_va(1, 4, 5, 'h001), "R3");
        // R3: 1 GB page
        do_lookup(mk_va(2, 7, 9, 'h001), "R3");
        do_lookup(mk_va(2, 300, 1, 'hfff), "R3");
        do_lookup(mk_va(6, 7, 9, 'h001), "R3");
        // R3: 4 KB neighbour is a different page
        do_lookup(mk_va(0, 0, 6, 'h010), "R3");

        // R6: fault region, walked twice
        do_lookup(mk_va(3, 1, 1, 'h020), "R6");
        do_lookup(mk_va(3, 1, 1, 'h020), "R6");

        // R9: flush then previously stored page walks again
        do_flush();
        do_lookup(mk_va(0, 0, 5, 'h123), "R9");

        // R8: fill all entries, then rotate
        do_flush();
        for (int i = 0; i < NENT; i++) do_lookup(mk_va(4, 0, i, 'h0), "R8");
        do_lookup(mk_va(4, 0, 16, 'h0), "R8");
        do_lookup(mk_va(4, 0, 1, 'h0), "R8");
        do_lookup(mk_va(4, 0, 0, 'h0), "R8");
        do_lookup(mk_va(4, 0, 1, 'h0), "R8");
        do_lookup(mk_va(4, 0, 2, 'h0), "R8");

        // R10: flush mid-walk and on the reply cycle
        flush_in_walk(mk_va(5, 2, 2, 'h0), 3);
        flush_in_walk(mk_va(4, 1, 3, 'h0), 0);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            wdelay = int'($urandom % 4);
            if (($urandom % 50) == 0) do_flush();
            do_lookup(mk_va(int'($urandom % 6), int'($urandom % 4),
                            int'($urandom % 12), int'($urandom % 4096)), "R5");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule